// File: doc/BRIEF.md
# CAN Fault Confinement Counter Unit

This block keeps the transmit and receive error counters of a CAN node and derives the node's error state from them. Frame parsing, bit timing and flag generation sit elsewhere. They report to this block through single-cycle pulses: detected transmit or receive errors, successful transmissions or receptions, and the end of the node's own active error flag, passive error flag or overload flag. A role input tells the block whether the node is currently the transmitter or a receiver.

After one of its own flags ends, the block watches the sampled bus level on each bit-time strobe and applies the post-flag dominant-bit rules. A receiver pays a penalty of 8 when the first bit after an error flag is dominant. A longer run of dominant bits is tolerated up to a limit. Once that limit is passed, a penalty of 8 goes to the counter matching the node's role, and another follows after every further eight dominant bits. A recessive sample ends the watch. The error state is error active, error passive or bus-off. Bus-off holds until an explicit recovery input clears it.

Top module: `can_fault_conf`

## Requirements
- R1: After reset both counters read 0 and `err_state` reads 0 (error active).
- R2: An `err_tx` pulse adds 8 to the transmit counter and an `err_rx` pulse adds 1 to the receive counter. Both counters are 9 bits wide and saturate at 511.
- R3: An `ok_tx` pulse subtracts 1 from the transmit counter and an `ok_rx` pulse subtracts 1 from the receive counter. Neither counter goes below 0.
- R4: When the node is a receiver (`is_tx`=0) and the first `bit_stb` after an active or passive error flag end samples `bus_dom`=1, the receive counter gains 8. There is no such penalty after an overload flag, for a transmitter, or when the first sample is recessive.
- R5: Counting from the first bit after the flag end, the 14th consecutive dominant sample after an active error flag or overload flag adds 8, and so does the 8th after a passive error flag. The penalty goes to the transmit counter when `is_tx`=1 and to the receive counter otherwise. Earlier dominant samples in the run add nothing from this rule.
- R6: After that first penalty, every further 8 consecutive dominant samples add another 8 to the same counter.
- R7: A recessive sample during the watch ends it. Dominant samples that follow, before the next flag end pulse, change no counter.
- R8: `err_state` is 1 (error passive) when either counter exceeds 127 and it is 0 (error active) when both counters are at or below 127, provided the node is not bus-off.
- R9: When the transmit counter exceeds 255, `err_state` becomes 2 (bus-off) in the same cycle the counter changes. Bus-off is sticky and both counters freeze while it lasts. A `busoff_clr` pulse during bus-off sets both counters to 0 and the state to error active. A `busoff_clr` pulse outside bus-off has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe per bit time at the sample point |
| bus_dom | input | 1 | Sampled bus level, 1 = dominant |
| is_tx | input | 1 | Node role: 1 = transmitter, 0 = receiver |
| flag_end_act | input | 1 | Pulse: the node's active error flag has ended |
| flag_end_pas | input | 1 | Pulse: the node's passive error flag has ended |
| flag_end_ovl | input | 1 | Pulse: the node's overload flag has ended |
| err_tx | input | 1 | Pulse: error detected while transmitting |
| err_rx | input | 1 | Pulse: error detected while receiving |
| ok_tx | input | 1 | Pulse: frame transmitted successfully |
| ok_rx | input | 1 | Pulse: frame received successfully |
| busoff_clr | input | 1 | Pulse: leave bus-off and clear both counters |
| tec | output | 9 | Transmit error counter |
| rec | output | 9 | Receive error counter |
| err_state | output | 2 | 0 error active, 1 error passive, 2 bus-off |

## Verification
Each counter result is due at the first clock edge that samples the pulse or strobe causing it. `err_state` is decoded combinationally from the updated counters and the bus-off flag, so it is valid in the same cycle as the counters. The bench drives every stimulus on a falling edge, holds it across exactly one rising edge, and reads both counters and the state on the following falling edge. Each result is therefore checked in the one cycle where it must appear. Long runs of dominant bits are checked one sample before and exactly at each penalty position, so an off-by-one in the run limits shows up.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    localparam int CNT_W       = 9;
    localparam int PASSIVE_LIM = 127;
    localparam int BOFF_LIM    = 255;
    localparam int RUN_W       = 4;
    localparam int ACT_RUN_LIM = 14;
    localparam int PAS_RUN_LIM = 8;
    localparam int RUN_REPEAT  = 8;
    localparam int ERR_STEP    = 8;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_PASSIVE = 2'd1,
        ST_BUSOFF  = 2'd2
    } fc_state_e;

    typedef struct packed {
        logic             watch;
        logic             first;
        logic             pas_lim;
        logic [RUN_W-1:0] run;
    } seq_t;

    function automatic logic [RUN_W-1:0] run_limit(input logic pas);
        return pas ? RUN_W'(PAS_RUN_LIM) : RUN_W'(ACT_RUN_LIM);
    endfunction

endpackage

// File: rtl/can_fc_seq.sv
module can_fc_seq
    import can_fc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic bus_dom,
    input  logic is_tx,
    input  logic flag_end_act,
    input  logic flag_end_pas,
    input  logic flag_end_ovl,
    output logic pen_tx,
    output logic pen_rx
);

    seq_t             q;
    logic             any_flag;
    logic             dom_hit;
    logic             lim_hit;
    logic [RUN_W-1:0] run_nx;
    logic [RUN_W-1:0] lim;

    always_comb begin
        any_flag = flag_end_act | flag_end_pas | flag_end_ovl;
        lim      = run_limit(q.pas_lim);
        run_nx   = q.run + 1'b1;
        dom_hit  = bit_stb & q.watch & bus_dom & ~any_flag;
        lim_hit  = dom_hit & (run_nx == lim);
        pen_tx   = lim_hit & is_tx;
        pen_rx   = (lim_hit | (dom_hit & q.first)) & ~is_tx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (any_flag) begin
            q.watch   <= 1'b1;
            q.first   <= ~flag_end_ovl;
            q.pas_lim <= flag_end_pas;
            q.run     <= '0;
        end else if (bit_stb && q.watch) begin
            q.first <= 1'b0;
            if (!bus_dom) begin
                q.watch <= 1'b0;
                q.run   <= '0;
            end else if (run_nx == lim) begin
                q.run <= lim - RUN_W'(RUN_REPEAT);
            end else begin
                q.run <= run_nx;
            end
        end
    end

endmodule

// File: rtl/can_fc_ctr.sv
module can_fc_ctr
    import can_fc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             clr,
    input  logic             inc_big,
    input  logic             inc_one,
    input  logic             dec_one,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W:0] MAXV = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0] sum;

    always_comb begin
        sum = {1'b0, cnt}
            + (inc_big ? (CNT_W+1)'(ERR_STEP) : '0)
            + (inc_one ? (CNT_W+1)'(1) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (hold) begin
            cnt <= cnt;
        end else if (inc_big || inc_one) begin
            cnt <= (sum > MAXV) ? MAXV[CNT_W-1:0] : sum[CNT_W-1:0];
        end else if (dec_one && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/can_fc_state.sv
module can_fc_state
    import can_fc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_req,
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    output logic             boff,
    output fc_state_e        state
);

    logic boff_q;

    always_comb begin
        boff = boff_q | (tec > CNT_W'(BOFF_LIM));
        if (boff)
            state = ST_BUSOFF;
        else if (tec > CNT_W'(PASSIVE_LIM) || rec > CNT_W'(PASSIVE_LIM))
            state = ST_PASSIVE;
        else
            state = ST_ACTIVE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            boff_q <= 1'b0;
        else if (boff && clr_req)
            boff_q <= 1'b0;
        else
            boff_q <= boff;
    end

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
    import can_fc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_stb,
    input  logic       bus_dom,
    input  logic       is_tx,
    input  logic       flag_end_act,
    input  logic       flag_end_pas,
    input  logic       flag_end_ovl,
    input  logic       err_tx,
    input  logic       err_rx,
    input  logic       ok_tx,
    input  logic       ok_rx,
    input  logic       busoff_clr,
    output logic [8:0] tec,
    output logic [8:0] rec,
    output logic [1:0] err_state
);

    logic      pen_tx;
    logic      pen_rx;
    logic      boff;
    logic      clr_go;
    fc_state_e state;

    assign clr_go    = boff & busoff_clr;
    assign err_state = state;

    can_fc_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .bit_stb      (bit_stb),
        .bus_dom      (bus_dom),
        .is_tx        (is_tx),
        .flag_end_act (flag_end_act),
        .flag_end_pas (flag_end_pas),
        .flag_end_ovl (flag_end_ovl),
        .pen_tx       (pen_tx),
        .pen_rx       (pen_rx)
    );

    can_fc_ctr u_tec (
        .clk     (clk),
        .rst     (rst),
        .hold    (boff),
        .clr     (clr_go),
        .inc_big (err_tx | pen_tx),
        .inc_one (1'b0),
        .dec_one (ok_tx),
        .cnt     (tec)
    );

    can_fc_ctr u_rec (
        .clk     (clk),
        .rst     (rst),
        .hold    (boff),
        .clr     (clr_go),
        .inc_big (pen_rx),
        .inc_one (err_rx),
        .dec_one (ok_rx),
        .cnt     (rec)
    );

    can_fc_state u_state (
        .clk     (clk),
        .rst     (rst),
        .clr_req (busoff_clr),
        .tec     (tec),
        .rec     (rec),
        .boff    (boff),
        .state   (state)
    );

endmodule

// File: rtl/can_fc_chk.sv
module can_fc_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] state,
    input logic [8:0] tec,
    input logic [8:0] rec,
    input logic       ok_tx,
    input logic       err_tx,
    input logic       clr,
    input logic       pen_tx,
    input logic       pen_rx
);

    AST_BOFF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd2 && !clr) |=> state == 2'd2); // R9

    AST_BOFF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd2 && clr) |=> (tec == 9'd0 && rec == 9'd0 && state == 2'd0)); // R9

    AST_TEC_DEC: assert property (@(posedge clk) disable iff (rst)
        (state != 2'd2 && ok_tx && !err_tx && !pen_tx && tec != 9'd0)
        |=> tec == $past(tec) - 9'd1); // R3

    AST_TEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (state != 2'd2) |=> (tec == $past(tec) || tec == $past(tec) - 9'd1
                             || tec == $past(tec) + 9'd8 || tec == 9'd511)); // R2

    AST_PEN_ONE_ROLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pen_tx, pen_rx})); // R5

    AST_ACTIVE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd0) |-> (tec <= 9'd127 && rec <= 9'd127)); // R8

endmodule

bind can_fault_conf can_fc_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .state  (err_state),
    .tec    (tec),
    .rec    (rec),
    .ok_tx  (ok_tx),
    .err_tx (err_tx),
    .clr    (busoff_clr),
    .pen_tx (pen_tx),
    .pen_rx (pen_rx)
);

// File: tb/can_fault_conf_bench.sv
`timescale 1ns/1ps
module can_fault_conf_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_stb = 0, bus_dom = 0, is_tx = 0;
    logic flag_end_act = 0, flag_end_pas = 0, flag_end_ovl = 0;
    logic err_tx = 0, err_rx = 0, ok_tx = 0, ok_rx = 0, busoff_clr = 0;
    logic [8:0] tec, rec;
    logic [1:0] err_state;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    can_fault_conf u_can_fault_conf (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .bus_dom(bus_dom), .is_tx(is_tx),
        .flag_end_act(flag_end_act), .flag_end_pas(flag_end_pas), .flag_end_ovl(flag_end_ovl),
        .err_tx(err_tx), .err_rx(err_rx), .ok_tx(ok_tx), .ok_rx(ok_rx),
        .busoff_clr(busoff_clr), .tec(tec), .rec(rec), .err_state(err_state)
    );

    // op codes: 0 err_tx, 1 err_rx, 2 ok_tx, 3 ok_rx ; {op, count, exp_tec, exp_rec}
    localparam logic [27:0] TBL [6] = '{
        {2'd0, 8'd3,  9'd24, 9'd0},   // R2
        {2'd1, 8'd5,  9'd24, 9'd5},   // R2
        {2'd2, 8'd4,  9'd20, 9'd5},   // R3
        {2'd3, 8'd7,  9'd20, 9'd0},   // R3 floor
        {2'd2, 8'd25, 9'd0,  9'd0},   // R3 floor
        {2'd1, 8'd2,  9'd0,  9'd2}    // R2
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk3(input string req, input int et, input int er, input int es);
        chk({req, " tec"}, int'(tec), et);
        chk({req, " rec"}, int'(rec), er);
        chk({req, " state"}, int'(err_state), es);
    endtask

    task automatic step(input logic et, input logic er, input logic ot, input logic orx,
                        input logic bs, input logic dom, input logic fa, input logic fp,
                        input logic fo, input logic cl);
        err_tx = et; err_rx = er; ok_tx = ot; ok_rx = orx; bit_stb = bs; bus_dom = dom;
        flag_end_act = fa; flag_end_pas = fp; flag_end_ovl = fo; busoff_clr = cl;
        @(negedge clk);
        err_tx = 0; err_rx = 0; ok_tx = 0; ok_rx = 0; bit_stb = 0;
        flag_end_act = 0; flag_end_pas = 0; flag_end_ovl = 0; busoff_clr = 0;
    endtask

    task automatic bits(input int n, input logic dom);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, dom, 0, 0, 0, 0);
    endtask

    task automatic op_n(input logic [1:0] op, input int n);
        for (int i = 0; i < n; i++)
            step(op == 2'd0, op == 2'd1, op == 2'd2, op == 2'd3, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 0;
        chk3("R1 reset", 0, 0, 0);

        for (int k = 0; k < 6; k++) begin
            op_n(TBL[k][27:26], int'(TBL[k][25:18]));
            chk("R2/R3 table tec", int'(tec), int'(TBL[k][17:9]));
            chk("R2/R3 table rec", int'(rec), int'(TBL[k][8:0]));
        end

        rst = 1; @(negedge clk); rst = 0;
        chk3("R1 re-reset", 0, 0, 0);

        // receiver after active flag
        is_tx = 0;
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        bits(1, 1);  chk("R4 first dominant", int'(rec), 8);
        bits(12, 1); chk("R5 bit 13 tolerated", int'(rec), 8);
        bits(1, 1);  chk("R5 bit 14 penalty", int'(rec), 16);
        bits(7, 1);  chk("R6 bit 21", int'(rec), 16);
        bits(1, 1);  chk("R6 bit 22 penalty", int'(rec), 24);
        bits(1, 0);  bits(20, 1);
        chk("R7 after recessive", int'(rec), 24);

        // first sample recessive
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        bits(1, 0);  chk("R4 recessive first", int'(rec), 24);
        bits(14, 1); chk("R7 watch ended", int'(rec), 24);

        // overload flag, receiver
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        bits(1, 1);  chk("R4 overload no first penalty", int'(rec), 24);
        bits(12, 1); chk("R5 overload bit 13", int'(rec), 24);
        bits(1, 1);  chk("R5 overload bit 14", int'(rec), 32);
        bits(1, 0);

        // transmitter, passive flag
        is_tx = 1;
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        bits(1, 1);  chk3("R4 transmitter no first penalty", 0, 32, 0);
        bits(6, 1);  chk("R5 passive bit 7", int'(tec), 0);
        bits(1, 1);  chk3("R5 passive bit 8", 8, 32, 0);
        bits(7, 1);  chk("R6 passive bit 15", int'(tec), 8);
        bits(1, 1);  chk("R6 passive bit 16", int'(tec), 16);
        bits(1, 0);
        is_tx = 0;

        // passive boundary
        op_n(2'd1, 95); chk3("R8 rec 127 active", 16, 127, 0);
        op_n(2'd1, 1);  chk3("R8 rec 128 passive", 16, 128, 1);
        op_n(2'd3, 1);  chk3("R8 back to active", 16, 127, 0);

        // bus-off
        op_n(2'd0, 29); chk3("R8 tec 248 passive", 248, 127, 1);
        op_n(2'd0, 1);  chk3("R9 tec 256 bus-off", 256, 127, 2);
        op_n(2'd2, 1);  op_n(2'd1, 1);
        chk3("R9 frozen and sticky", 256, 127, 2);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk3("R9 recovery", 0, 0, 0);
        op_n(2'd0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk3("R9 clear ignored outside bus-off", 8, 0, 0);

        // receive saturation
        op_n(2'd1, 515);
        chk3("R2 rec saturates", 8, 511, 1);

        finish_run();
    end

endmodule